// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write Protection

This block is the slave side of a two-wire serial bus (I2C style) in front of an on-chip byte memory. SCL and SDA come from the pads. They pass through two-flop synchronizers, and a condition detector compares successive synchronized samples on the fast system clock. A bus master selects the block with a device byte. It then sends a two-byte memory address, high byte first. After that it writes data bytes, or it reads bytes back after a repeated start. A current-address read resumes at the internal pointer.

The device byte has a fixed family code in its upper bits and three strap bits. Up to eight copies can therefore share one bus. SDA is open-drain. The block only asserts `sda_oe` to pull the line low and never drives a high. The write-protect input keeps every acknowledge on the address phase, refuses each data byte with a NACK, and leaves the memory untouched. Reads behave the same whatever its level.

The memory has `2**ADDR_W` bytes. `ADDR_W` is a parameter in the range 9 to 16. The 64-kbit configuration (8192 x 8, a 13-bit pointer) is `ADDR_W = 13`. The default is 11 to keep elaboration small. There is no valid/ready stream here: the only data path is the bus itself, and the bus master paces every byte, so the block has no back-pressure rules.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset `sda_oe` is 0 and the block waits for a start condition.
- R2: The device byte is compared as follows. Bits 7:4 must be 4'b1010 and bits 3:1 must equal `strap`. On a match the block drives ACK (SDA low) in the ninth clock. On a mismatch it leaves SDA released (NACK) and ignores every later byte until the next start.
- R3: Bit 0 of the device byte selects the direction: 0 is write and 1 is read.
- R4: A write-direction transfer continues with two address bytes, high byte first, and each byte is acknowledged. The pointer takes the low `ADDR_W` bits of the 16 received bits, and the higher bits are ignored.
- R5: While `wp` is 0, each data byte after the address is stored at the pointer and acknowledged. The pointer then advances, and it wraps from `2**ADDR_W-1` to 0.
- R6: While `wp` is 1, the device and address bytes are still acknowledged, every data byte gets a NACK, and the memory keeps its old contents.
- R7: A random read consists of a write-direction device byte and two address bytes, then a repeated start and a read-direction device byte. It returns the byte at the given address.
- R8: A read that starts directly with a read-direction device byte returns the byte at the current pointer, which is the address after the last byte transferred.
- R9: In a read, a master ACK after a byte makes the block send the byte at the next address, wrapping at the top of memory. A master NACK ends the read and SDA stays released.
- R10: The block changes `sda_oe` only while SCL is low. Data is sampled on SCL rising edges and output changes after SCL falling edges.
- R11: SDA falling while SCL is high is a start condition and restarts device matching. SDA rising while SCL is high is a stop condition and returns the block to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Level of the SDA line as seen on the bus |
| strap | input | 3 | Device-select straps compared with device byte bits 3:1 |
| wp | input | 1 | Write protect: 1 refuses every data write |
| sda_oe | output | 1 | 1 pulls SDA low. 0 releases the line, which then reads high |

## Verification
The assertions take the bus as well formed. A master changes SDA only while SCL is low, except at start and stop. Every SCL phase lasts several system clocks, so each synchronized edge is seen once. The master releases SDA whenever the slave owns the ninth bit or a read byte. The bench drives SCL with a quarter period of eight system clocks and sets SDA a full quarter after SCL falls. It models the wired line as the AND of the master's level and the slave's inverted output enable. Apart from the deliberate start and stop, it never lets SDA move while SCL is high.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AHI, ST_AHI_ACK, ST_ALO, ST_ALO_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } twi_state_e;
  localparam logic [3:0] FAMILY_CODE = 4'b1010;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) pipe[s] <= '1;
      else if (s == 0) pipe[s] <= d;
      else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_mem.sv
module twi_mem #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       sda_oe
);
  localparam int unsigned HI_W = ADDR_W - BYTE_W;

  logic [1:0]        sync_q;
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  twi_state_e        state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh, rb, rdata;
  logic [HI_W-1:0]   ahi;
  logic [ADDR_W-1:0] ptr;
  logic              rw, mack, mem_we, dev_hit, byte_in;

  twi_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  twi_cond_det u_det (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twi_mem #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(ptr), .wdata(sh), .rdata(rdata)
  );

  assign dev_hit = (sh[7:4] == FAMILY_CODE) && (sh[3:1] == strap);
  assign byte_in = scl_fall && (cnt == 4'd8);
  assign mem_we  = byte_in && (state == ST_WR) && !wp && !start_ev && !stop_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; sda_oe <= 1'b0; cnt <= '0; sh <= '0; rb <= '0;
      ahi <= '0; ptr <= '0; rw <= 1'b0; mack <= 1'b0;
    end else if (start_ev) begin
      state <= ST_DEV; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE; sda_oe <= 1'b0;
    end else begin
      if (scl_rise) begin
        case (state)
          ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end
          ST_RD_ACK: mack <= ~sda_s;
          default: ;
        endcase
      end
      if (scl_fall) begin
        case (state)
          ST_DEV: if (cnt == 4'd8) begin
            cnt <= '0;
            if (dev_hit) begin
              rw <= sh[0]; sda_oe <= 1'b1; state <= ST_DEV_ACK;
            end else state <= ST_IDLE;
          end
          ST_DEV_ACK: if (rw) begin
            rb <= rdata; sda_oe <= ~rdata[7]; cnt <= '0; state <= ST_RD;
          end else begin
            sda_oe <= 1'b0; state <= ST_AHI;
          end
          ST_AHI: if (cnt == 4'd8) begin
            cnt <= '0; ahi <= sh[HI_W-1:0]; sda_oe <= 1'b1; state <= ST_AHI_ACK;
          end
          ST_AHI_ACK: begin sda_oe <= 1'b0; state <= ST_ALO; end
          ST_ALO: if (cnt == 4'd8) begin
            cnt <= '0; ptr <= {ahi, sh}; sda_oe <= 1'b1; state <= ST_ALO_ACK;
          end
          ST_ALO_ACK: begin sda_oe <= 1'b0; state <= ST_WR; end
          ST_WR: if (cnt == 4'd8) begin
            cnt <= '0; ptr <= ptr + 1'b1; sda_oe <= ~wp; state <= ST_WR_ACK;
          end
          ST_WR_ACK: begin sda_oe <= 1'b0; state <= ST_WR; end
          ST_RD: if (cnt == 4'd7) begin
            sda_oe <= 1'b0; ptr <= ptr + 1'b1; state <= ST_RD_ACK;
          end else begin
            rb <= {rb[6:0], 1'b0}; sda_oe <= ~rb[6]; cnt <= cnt + 4'd1;
          end
          ST_RD_ACK: if (mack) begin
            rb <= rdata; sda_oe <= ~rdata[7]; cnt <= '0; state <= ST_RD;
          end else begin
            sda_oe <= 1'b0; state <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
  import twi_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wp,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       mem_we,
  input twi_state_e state
);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));

  // R6
  wp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp);

  // R11
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_DEV && !sda_oe));

  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE && !sda_oe));

  // R2
  dev_ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV_ACK) |-> sda_oe);

  // R1
  reset_release_chk: assert property (@(posedge clk)
    !rst_n |=> !sda_oe);
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp(wp), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_ev(start_ev), .stop_ev(stop_ev), .mem_we(mem_we), .state(state)
);

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;
  localparam int AW = 11;
  localparam int Q  = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0]    ref_m [0:(1<<AW)-1];
  logic [AW-1:0] bptr = '0;
  logic [7:0]    exp_q [$];
  string         tag_q [$];
  logic [7:0]    got;
  event          got_ev;

  always #10 clk = ~clk;

  twi_mem_slave #(.ADDR_W(AW)) i_twi_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .strap(STRAP), .wp(wp), .sda_oe(sda_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor: pops the scoreboard as read bytes arrive
  always @(got_ev) begin
    if (exp_q.size() == 0) check("R9 unexpected byte", got, 8'hxx);
    else check(tag_q.pop_front(), got, exp_q.pop_front());
  end

  task automatic wq(); repeat (Q) @(posedge clk); #2; endtask
  task automatic bus_start(); m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq(); endtask
  task automatic bus_stop(); m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(); endtask
  task automatic send_bit(input logic b); m_sda = b; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq(); endtask
  task automatic recv_bit(output logic b);
    m_sda = 1; wq(); m_scl = 1; wq(); b = sda_bus; wq(); m_scl = 0; wq();
  endtask
  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask
  task automatic recv_byte(output logic [7:0] v, input logic mack);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
    send_bit(~mack);
  endtask

  task automatic send_addr(input logic [15:0] a);
    logic ack;
    send_byte(a[15:8], ack); check("R4 high address ack", ack, 1);
    send_byte(a[7:0], ack);  check("R4 low address ack", ack, 1);
    bptr = a[AW-1:0];
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] base);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack); check("R2 device match ack", ack, 1);
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = base + 8'(i * 8'h11);
      send_byte(d, ack);
      if (wp) check("R6 data NACK under write protect", ack, 0);
      else begin
        check("R5 data ack", ack, 1);
        ref_m[bptr] = d;
      end
      bptr = bptr + 1'b1;
    end
    bus_stop();
  endtask

  task automatic read_bytes(input int n, input string tag);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ref_m[bptr]); tag_q.push_back(tag);
      recv_byte(v, i < n-1);
      got = v; -> got_ev; #1;
      bptr = bptr + 1'b1;
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack); check("R7 device ack", ack, 1);
    send_addr(a);
    bus_start();
    send_byte(DEV_R, ack); check("R3 read direction ack", ack, 1);
    read_bytes(n, tag);
  endtask

  task automatic cur_read(input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(DEV_R, ack); check("R8 current read ack", ack, 1);
    read_bytes(n, tag);
  endtask

  initial begin
    logic ack;
    repeat (5) @(posedge clk); #2;
    check("R1 sda released in reset", sda_oe, 0);
    rst_n = 1;
    repeat (5) @(posedge clk); #2;
    check("R1 sda released after reset", sda_oe, 0);

    do_write(16'h0012, 1, 8'h5A);
    rand_read(16'h0012, 1, "R7 random read");

    do_write(16'h0100, 4, 8'h21);
    rand_read(16'h0100, 3, "R9 sequential read");
    cur_read(1, "R8 current address read");

    // R2: wrong strap and wrong family get NACK, later bytes ignored
    bus_start();
    send_byte({4'b1010, 3'b010, 1'b0}, ack); check("R2 strap mismatch NACK", ack, 0);
    send_byte(8'h00, ack); check("R2 ignored until start", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1001, STRAP, 1'b0}, ack); check("R2 family mismatch NACK", ack, 0);
    bus_stop();

    // R6: write protect keeps acks on address, NACKs data, memory unchanged
    wp = 1;
    do_write(16'h0012, 2, 8'hE7);
    rand_read(16'h0012, 2, "R6 memory unchanged under write protect");
    wp = 0;

    // R4/R5/R9: upper address bits ignored, write and read wrap at top
    do_write(16'hFFFF, 2, 8'hC3);
    rand_read(16'h07FF, 2, "R9 read wraps to address 0");
    rand_read(16'h0000, 1, "R5 write wrapped to address 0");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule